// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog peripheral. It sits on a simple register bus and counts a slow time base. Software controls it only by writing 16-bit code words to a key register. One code starts the watchdog and another refreshes it. A third code opens the prescaler and reload registers for writing, and any other code closes them again. Once the watchdog is running, nothing except a reset stops it.

A power-of-two prescaler divides the slow time base. The divided ticks decrement a 12-bit counter. When the counter is already at zero, the next divided tick raises a one-cycle reset request and the counter starts again from the reload value. New prescaler and reload values do not take effect at once. They move into the counting logic over a fixed number of slow ticks, and a status flag for each register stays set until the new value is in use.

The slow time base arrives as a one-cycle strobe, `tick`, in the bus clock domain. Each strobe stands for one edge of the counting clock.

Top module: `wdg_keyed_timer`

## Requirements
- R1: After reset, the prescaler register (0x04) reads 0, the reload register (0x08) reads 0xFFF and the status register (0x0C) reads 0. `rst_req` stays low, and the watchdog is not running.
- R2: Writing 0x5555 to the key register (0x00, bits 15:0) unlocks the prescaler and reload registers. Any other key value written locks them again. While they are locked, writes to 0x04 or 0x08 are ignored: the read-back value does not change and the status does not change.
- R3: The prescaler field is bits 2:0 at 0x04 and selects a division by 4·2^PR. A written value above 6 is stored as 6. The reload field is bits 11:0 at 0x08. The timeout is (reload+1)·divider ticks.
- R4: A write to the prescaler sets status bit 0, and a write to the reload sets status bit 1. The bit stays set until the 5th tick after the write. On that tick the bit clears and the new value takes effect.
- R5: Writing 0xCCCC to the key register starts the watchdog from the active reload value. The `rst_req` output goes high for one clock, in the cycle after the tick that completes the timeout.
- R6: After a reset request, the counter reloads and keeps counting. The next request follows one full timeout later.
- R7: Writing 0xAAAA to the key register while the watchdog is running restarts a full timeout period.
- R8: No key value stops a running watchdog; writing 0x0000, for example, leaves the timeout schedule unchanged. Ticks given before the watchdog starts never raise `rst_req`.
- R9: The key register (0x00) and the window offset (0x10) both read as 0. A write to 0x10 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (when selected) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick | input | 1 | One-cycle strobe per counting-clock edge |
| rst_req | output | 1 | One-clock reset request pulse |

## Verification
Register read data is combinational, so the bench samples it one nanosecond after it sets up a read. A register write is visible in that way at the next falling edge. Each tick strobe is held for one clock. The bench samples `rst_req` and the status flags at the falling edge after that clock, because both update at that clock's rising edge. Timeouts are measured as the index of the first tick whose following cycle shows `rst_req`, and the bench compares that index with (reload+1)·divider computed from the values it wrote.

// File: rtl/wdg_pkg.sv
// Package: register offsets and key codes shared by the watchdog modules.
// Assumes a byte-addressed register map with 32-bit aligned registers.
package wdg_pkg;
    localparam int          ADDR_W      = 5;
    localparam int          KEY_W       = 16;
    localparam logic [ADDR_W-1:0] OFS_KEY   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RLD   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_WIN   = 5'h10;
    localparam logic [KEY_W-1:0]  KEY_OPEN    = 16'h5555;
    localparam logic [KEY_W-1:0]  KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0]  KEY_REFRESH = 16'hAAAA;
endpackage

// File: rtl/wdg_key_ctrl.sv
// Module: key decoder. Decodes the key register writes into the lock state,
// the sticky run state, and the start and refresh load strobes.
// Assumes key_wr lasts one clock for each bus write.
module wdg_key_ctrl
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output logic             unlocked,
    output logic             running,
    output logic             load_req
);
    logic is_start;
    logic is_refresh;

    // Classify the written key code.
    always_comb begin
        is_start   = key_wr && (key_val == KEY_START);
        is_refresh = key_wr && (key_val == KEY_REFRESH);
        load_req   = (is_start && !running) || (is_refresh && running);
    end

    // Lock follows the last key code written; the run state never clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            running  <= 1'b0;
        end else if (key_wr) begin
            unlocked <= (key_val == KEY_OPEN);
            if (is_start) running <= 1'b1;
        end
    end
endmodule

// File: rtl/wdg_cfg_sync.sv
// Module: configuration transfer. Holds a written value and passes it to the
// counting logic only after SYNC_TICKS slow ticks, with a busy flag meanwhile.
// Assumes a write and a tick never need to be honoured in the same clock;
// when they coincide the write wins and restarts the transfer.
module wdg_cfg_sync #(
    parameter int             W          = 12,
    parameter int             SYNC_TICKS = 5,
    parameter logic [W-1:0]   RST_VAL    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         tick,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         busy
);
    localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

    logic [SYNC_W-1:0] busy_cnt;

    // Flag the transfer as in progress while the countdown is not zero.
    always_comb busy = (busy_cnt != '0);

    // Capture writes and move the value across after the tick countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow   <= RST_VAL;
            active   <= RST_VAL;
            busy_cnt <= '0;
        end else if (wr_en) begin
            shadow   <= wr_val;
            busy_cnt <= SYNC_W'(SYNC_TICKS);
        end else if (tick && busy) begin
            busy_cnt <= busy_cnt - 1'b1;
            if (busy_cnt == SYNC_W'(1)) active <= shadow;
        end
    end
endmodule

// File: rtl/wdg_counter.sv
// Module: prescaler and down-counter. Divides the tick strobe by 4<<pr and
// decrements the counter on each divided tick. When the counter is already
// zero, it pulses rst_req for one clock and reloads.
// Assumes pr never exceeds the largest supported exponent.
module wdg_counter #(
    parameter int CNT_W = 12,
    parameter int PR_W  = 3,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             running,
    input  logic             load,
    input  logic [PR_W-1:0]  pr_act,
    input  logic [CNT_W-1:0] rld_act,
    output logic             rst_req
);
    logic [DIV_W:0]     div_full;
    logic [DIV_W-1:0]   div_last;
    logic [DIV_W-1:0]   pre_cnt;
    logic [CNT_W-1:0]   cnt;

    // Last prescaler count before a divided tick.
    always_comb begin
        div_full = (DIV_W + 1)'(4) << pr_act;
        div_last = DIV_W'(div_full - 1'b1);
    end

    // Prescale the ticks, count down, and raise the request at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            cnt     <= '1;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (load) begin
                pre_cnt <= '0;
                cnt     <= rld_act;
            end else if (running && tick) begin
                if (pre_cnt >= div_last) begin
                    pre_cnt <= '0;
                    if (cnt == '0) begin
                        cnt     <= rld_act;
                        rst_req <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdg_keyed_timer.sv
// Module: top of the key-protected watchdog. Decodes register bus accesses,
// gates configuration writes by the key lock, and joins the key decoder,
// the two configuration transfers and the counter.
// Assumes one bus access per clock and a combinational read path.
module wdg_keyed_timer
    import wdg_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int CNT_W        = 12,
    parameter int MAX_DIV_LOG2 = 8,
    parameter int SYNC_TICKS   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output logic              rst_req
);
    localparam int MAX_PR = MAX_DIV_LOG2 - 2;
    localparam int PR_W   = $clog2(MAX_PR + 1);
    localparam int DIV_W  = MAX_DIV_LOG2;

    logic              wr_any;
    logic              key_wr;
    logic              pre_wr;
    logic              rld_wr;
    logic [PR_W-1:0]   pr_wval;
    logic              unlocked;
    logic              running;
    logic              load_req;
    logic [PR_W-1:0]   pr_shadow;
    logic [PR_W-1:0]   pr_act;
    logic              pvu;
    logic [CNT_W-1:0]  rld_shadow;
    logic [CNT_W-1:0]  rld_act;
    logic              rvu;

    // Decode writes and gate configuration writes with the lock.
    always_comb begin
        wr_any = bus_sel && bus_wr;
        key_wr = wr_any && (bus_addr == OFS_KEY);
        pre_wr = wr_any && (bus_addr == OFS_PRE) && unlocked;
        rld_wr = wr_any && (bus_addr == OFS_RLD) && unlocked;
        if (bus_wdata > DATA_W'(MAX_PR)) pr_wval = PR_W'(MAX_PR);
        else                             pr_wval = bus_wdata[PR_W-1:0];
    end

    wdg_key_ctrl i_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_val  (bus_wdata[KEY_W-1:0]),
        .unlocked (unlocked),
        .running  (running),
        .load_req (load_req)
    );

    wdg_cfg_sync #(.W(PR_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pre_wr),
        .wr_val (pr_wval),
        .tick   (tick),
        .shadow (pr_shadow),
        .active (pr_act),
        .busy   (pvu)
    );

    wdg_cfg_sync #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('1)) i_rld (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rld_wr),
        .wr_val (bus_wdata[CNT_W-1:0]),
        .tick   (tick),
        .shadow (rld_shadow),
        .active (rld_act),
        .busy   (rvu)
    );

    wdg_counter #(.CNT_W(CNT_W), .PR_W(PR_W), .DIV_W(DIV_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .running (running),
        .load    (load_req),
        .pr_act  (pr_act),
        .rld_act (rld_act),
        .rst_req (rst_req)
    );

    // Return the addressed register; write-only and unused offsets read 0.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_PRE:  bus_rdata = DATA_W'(pr_shadow);
                OFS_RLD:  bus_rdata = DATA_W'(rld_shadow);
                OFS_STAT: bus_rdata = DATA_W'({rvu, pvu});
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdg_keyed_timer_chk.sv
// Module: assertion checker for the watchdog top, attached with bind.
// Assumes the internal names of wdg_keyed_timer.
module wdg_keyed_timer_chk #(
    parameter int PR_W   = 3,
    parameter int CNT_W  = 12,
    parameter int MAX_PR = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             running,
    input logic             unlocked,
    input logic [PR_W-1:0]  pr_shadow,
    input logic [PR_W-1:0]  pr_act,
    input logic             pvu,
    input logic [CNT_W-1:0] rld_shadow,
    input logic [CNT_W-1:0] rld_act,
    input logic             rvu
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);                                   // R5
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !rst_req);                                  // R8
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);                                    // R8
    AST_LOCKED_PR: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(pr_shadow));                       // R2
    AST_LOCKED_RLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(rld_shadow));                      // R2
    AST_PR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pvu) |-> (pr_act == pr_shadow));                   // R4
    AST_RLD_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rvu) |-> (rld_act == rld_shadow));                 // R4
    AST_PR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        pr_shadow <= PR_W'(MAX_PR));                             // R3
endmodule

bind wdg_keyed_timer wdg_keyed_timer_chk #(
    .PR_W(PR_W), .CNT_W(CNT_W), .MAX_PR(MAX_PR)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .running    (running),
    .unlocked   (unlocked),
    .pr_shadow  (pr_shadow),
    .pr_act     (pr_act),
    .pvu        (pvu),
    .rld_shadow (rld_shadow),
    .rld_act    (rld_act),
    .rvu        (rvu)
);

// File: tb/test_wdg_keyed_timer.sv
`timescale 1ns/1ps
// Directed bench for the key-protected watchdog, one task per scenario.
module test_wdg_keyed_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wdg_keyed_timer i_wdg_keyed_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // One tick strobe; returns rst_req as seen in the following cycle.
    task automatic one_tick(output logic p);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        p = rst_req;
    endtask

    // Give n ticks; report the index of the first pulse and the pulse count.
    task automatic run_ticks(input int n, output int first, output int count);
        logic p;
        first = 0; count = 0;
        for (int i = 1; i <= n; i++) begin
            one_tick(p);
            if (p) begin
                count++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        bus_read(5'h04, d); chk("R1 prescaler", d, 0);
        bus_read(5'h08, d); chk("R1 reload", d, 32'hFFF);
        bus_read(5'h0C, d); chk("R1 status", d, 0);
        chk("R1 rst_req", {31'b0, rst_req}, 0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        bus_write(5'h04, 3);
        bus_read(5'h04, d); chk("R2 locked prescaler", d, 0);
        bus_read(5'h0C, d); chk("R2 locked status", d, 0);
        bus_write(5'h00, 32'h5555);
        bus_write(5'h00, 32'hAAAA);
        bus_write(5'h08, 5);
        bus_read(5'h08, d); chk("R2 relocked reload", d, 32'hFFF);
        bus_write(5'h00, 32'h5555);
        bus_write(5'h08, 5);
        bus_read(5'h08, d); chk("R2 unlocked reload", d, 5);
        bus_read(5'h00, d); chk("R9 key reads 0", d, 0);
        bus_write(5'h10, 32'h123);
        bus_read(5'h10, d); chk("R9 window reads 0", d, 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        int f, c;
        do_reset();
        bus_write(5'h00, 32'h5555);
        bus_write(5'h04, 7);
        bus_read(5'h04, d); chk("R3 prescaler saturates", d, 6);
        bus_read(5'h0C, d); chk("R4 status bit0 set", d, 1);
        run_ticks(4, f, c);
        bus_read(5'h0C, d); chk("R4 status after 4 ticks", d, 1);
        run_ticks(1, f, c);
        bus_read(5'h0C, d); chk("R4 status after 5 ticks", d, 0);
        bus_write(5'h08, 9);
        bus_read(5'h0C, d); chk("R4 status bit1 set", d, 2);
        run_ticks(5, f, c);
        bus_read(5'h0C, d); chk("R4 status bit1 clears", d, 0);
        chk("R8 no pulse while stopped", c, 0);
    endtask

    task automatic t_timeout();
        int f, c;
        do_reset();
        bus_write(5'h00, 32'h5555);
        bus_write(5'h08, 2);
        run_ticks(5, f, c);
        chk("R8 idle ticks no pulse", c, 0);
        bus_write(5'h00, 32'hCCCC);
        run_ticks(12, f, c);
        chk("R5 first timeout tick", f, 12);
        chk("R5 single pulse", c, 1);
        run_ticks(12, f, c);
        chk("R6 second period", f, 12);
        run_ticks(8, f, c);
        chk("R7 no pulse before refresh", c, 0);
        bus_write(5'h00, 32'hAAAA);
        run_ticks(12, f, c);
        chk("R7 full period after refresh", f, 12);
        bus_write(5'h00, 32'h0000);
        run_ticks(12, f, c);
        chk("R8 still running after key 0", f, 12);
    endtask

    task automatic t_divider();
        int f, c;
        do_reset();
        bus_write(5'h00, 32'h5555);
        bus_write(5'h04, 1);
        bus_write(5'h08, 3);
        run_ticks(5, f, c);
        bus_write(5'h00, 32'hCCCC);
        run_ticks(34, f, c);
        chk("R3 divide by 8 timeout", f, 32);
        chk("R3 one pulse in 34 ticks", c, 1);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        t_reset();
        t_lock();
        t_status();
        t_timeout();
        t_divider();
        report();
    end
endmodule